// File: doc/BRIEF.md
# Pipelined Fixed-Point Radix-2 Butterfly

This block computes one decimation-in-time radix-2 butterfly per clock on complex fixed-point data. It takes two complex operands, x1 and x2, and a complex twiddle W. It returns y1 = x1 + W·x2 and y2 = x1 - W·x2. The twiddle arrives as two separate words, c and d, and means W = c - jd. It is scaled so that 1.0 equals 2^TW_FRAC, which is Q2.14 at the default width.

The complex product is formed as t_re = x2_re·c + x2_im·d and t_im = x2_im·c - x2_re·d. The four real products run in parallel. Each full-width product is cut back to the data width before any addition: the slice starts at bit TW_FRAC, which keeps the data amplitude unchanged. The stage after the multipliers uses three adders and three subtractors. Sums wrap in two's complement and do not saturate, so overflow must be prevented by scaling the input.

The block has two register stages. A valid flag travels alongside the data, so a new butterfly can enter on every cycle. An FFT engine drives it from its operand memories and a twiddle table.

Top module: `radix2_bfly`

## Requirements
- R1: While rst_ni is low, valid_o and all four result outputs are 0.
- R2: valid_o is high exactly two rising edges after the edge that sampled valid_i high, and is low at every other time.
- R3: Each real product is taken as bits [TW_FRAC+DATA_W-1:TW_FRAC] of the full signed product, i.e. floor(a·b / 2^TW_FRAC) modulo 2^DATA_W. At the defaults this is bits [29:14], so (-32768)·(-32768) gives 0.
- R4: y1_re = x1_re + t_re and y1_im = x1_im + t_im, where t_re = P(x2_re,c) + P(x2_im,d) and t_im = P(x2_im,c) - P(x2_re,d), and P is the truncated product of R3.
- R5: y2_re = x1_re - t_re and y2_im = x1_im - t_im, computed with the same t as R4.
- R6: All additions and subtractions wrap modulo 2^DATA_W and never saturate.
- R7: While no result is being delivered, the four result outputs keep the last delivered values.
- R8: A new operand set is accepted on every cycle. Back-to-back inputs give back-to-back results in the same order.
- R9: Each of the four products is truncated on its own, before the terms are added. With c = d = 2^(TW_FRAC-1) and x2 = (1,1), t is (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand set present this cycle |
| x1_re_i | input | DATA_W | x1 real part |
| x1_im_i | input | DATA_W | x1 imaginary part |
| x2_re_i | input | DATA_W | x2 real part |
| x2_im_i | input | DATA_W | x2 imaginary part |
| tw_c_i | input | DATA_W | Twiddle real part c |
| tw_d_i | input | DATA_W | Twiddle negated imaginary part d (W = c - jd) |
| valid_o | output | 1 | Result present this cycle |
| y1_re_o | output | DATA_W | y1 real part |
| y1_im_o | output | DATA_W | y1 imaginary part |
| y2_re_o | output | DATA_W | y2 real part |
| y2_im_o | output | DATA_W | y2 imaginary part |

## Verification
The bench builds the block with its defaults, DATA_W = 16 and TW_FRAC = 14, so every twiddle can be written exactly as a 16-bit integer. These values make the extreme corners reachable. The product of two -32768 operands lands on bit 30, which tests that the slice really starts at bit 14. Operands at the edge of the range make the output sums wrap. Half-scale twiddles with unit operands separate truncation of each term from truncation of the sum. Negative odd products show floor rounding rather than rounding toward zero.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  parameter int unsigned DEF_DATA_W  = 16;
  parameter int unsigned DEF_TW_FRAC = 14;

  // Slot order of the four real products
  typedef enum logic [1:0] {
    MUL_RC = 2'd0,  // x2_re * c
    MUL_ID = 2'd1,  // x2_im * d
    MUL_IC = 2'd2,  // x2_im * c
    MUL_RD = 2'd3   // x2_re * d
  } mul_slot_e;

  localparam int unsigned NUM_MUL = 4;
endpackage

// File: rtl/bfly_mul_trunc.sv
module bfly_mul_trunc #(
  parameter int unsigned DATA_W  = bfly_pkg::DEF_DATA_W,
  parameter int unsigned TW_FRAC = bfly_pkg::DEF_TW_FRAC
) (
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [DATA_W-1:0] p_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  // Full product, then arithmetic shift by the twiddle scale; keep DATA_W bits
  assign p_o = DATA_W'((PROD_W'(a_i) * PROD_W'(b_i)) >>> TW_FRAC);
endmodule

// File: rtl/bfly_mul_stage.sv
module bfly_mul_stage #(
  parameter int unsigned DATA_W  = bfly_pkg::DEF_DATA_W,
  parameter int unsigned TW_FRAC = bfly_pkg::DEF_TW_FRAC
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 vld_i,
  input  logic [DATA_W-1:0]                    x1_re_i,
  input  logic [DATA_W-1:0]                    x1_im_i,
  input  logic [DATA_W-1:0]                    x2_re_i,
  input  logic [DATA_W-1:0]                    x2_im_i,
  input  logic [DATA_W-1:0]                    tw_c_i,
  input  logic [DATA_W-1:0]                    tw_d_i,
  output logic                                 vld_o,
  output logic [DATA_W-1:0]                    x1_re_o,
  output logic [DATA_W-1:0]                    x1_im_o,
  output logic [bfly_pkg::NUM_MUL-1:0][DATA_W-1:0] prod_o
);
  import bfly_pkg::*;

  logic [NUM_MUL-1:0][DATA_W-1:0] op_a;
  logic [NUM_MUL-1:0][DATA_W-1:0] op_b;
  logic [NUM_MUL-1:0][DATA_W-1:0] prod_d;

  always_comb begin
    op_a[MUL_RC] = x2_re_i;  op_b[MUL_RC] = tw_c_i;
    op_a[MUL_ID] = x2_im_i;  op_b[MUL_ID] = tw_d_i;
    op_a[MUL_IC] = x2_im_i;  op_b[MUL_IC] = tw_c_i;
    op_a[MUL_RD] = x2_re_i;  op_b[MUL_RD] = tw_d_i;
  end

  for (genvar g = 0; g < NUM_MUL; g++) begin : g_mul
    logic signed [DATA_W-1:0] p_s;
    bfly_mul_trunc #(
      .DATA_W (DATA_W),
      .TW_FRAC(TW_FRAC)
    ) u_mul (
      .a_i(op_a[g]),
      .b_i(op_b[g]),
      .p_o(p_s)
    );
    assign prod_d[g] = p_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      x1_re_o <= '0;
      x1_im_o <= '0;
      prod_o  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        x1_re_o <= x1_re_i;
        x1_im_o <= x1_im_i;
        prod_o  <= prod_d;
      end
    end
  end
endmodule

// File: rtl/bfly_sum_stage.sv
module bfly_sum_stage #(
  parameter int unsigned DATA_W = bfly_pkg::DEF_DATA_W
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 vld_i,
  input  logic [DATA_W-1:0]                    x1_re_i,
  input  logic [DATA_W-1:0]                    x1_im_i,
  input  logic [bfly_pkg::NUM_MUL-1:0][DATA_W-1:0] prod_i,
  output logic                                 vld_o,
  output logic [DATA_W-1:0]                    y1_re_o,
  output logic [DATA_W-1:0]                    y1_im_o,
  output logic [DATA_W-1:0]                    y2_re_o,
  output logic [DATA_W-1:0]                    y2_im_o
);
  import bfly_pkg::*;

  logic [DATA_W-1:0] t_re;
  logic [DATA_W-1:0] t_im;

  // Wrapping arithmetic: all operands and results share DATA_W
  assign t_re = prod_i[MUL_RC] + prod_i[MUL_ID];
  assign t_im = prod_i[MUL_IC] - prod_i[MUL_RD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      y1_re_o <= '0;
      y1_im_o <= '0;
      y2_re_o <= '0;
      y2_im_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        y1_re_o <= x1_re_i + t_re;
        y1_im_o <= x1_im_i + t_im;
        y2_re_o <= x1_re_i - t_re;
        y2_im_o <= x1_im_i - t_im;
      end
    end
  end
endmodule

// File: rtl/radix2_bfly.sv
module radix2_bfly #(
  parameter int unsigned DATA_W  = bfly_pkg::DEF_DATA_W,
  parameter int unsigned TW_FRAC = bfly_pkg::DEF_TW_FRAC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] x1_re_i,
  input  logic [DATA_W-1:0] x1_im_i,
  input  logic [DATA_W-1:0] x2_re_i,
  input  logic [DATA_W-1:0] x2_im_i,
  input  logic [DATA_W-1:0] tw_c_i,
  input  logic [DATA_W-1:0] tw_d_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] y1_re_o,
  output logic [DATA_W-1:0] y1_im_o,
  output logic [DATA_W-1:0] y2_re_o,
  output logic [DATA_W-1:0] y2_im_o
);
  import bfly_pkg::*;

  logic                           s1_vld;
  logic [DATA_W-1:0]              s1_x1_re;
  logic [DATA_W-1:0]              s1_x1_im;
  logic [NUM_MUL-1:0][DATA_W-1:0] s1_prod;

  bfly_mul_stage #(
    .DATA_W (DATA_W),
    .TW_FRAC(TW_FRAC)
  ) u_mul_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (valid_i),
    .x1_re_i(x1_re_i),
    .x1_im_i(x1_im_i),
    .x2_re_i(x2_re_i),
    .x2_im_i(x2_im_i),
    .tw_c_i (tw_c_i),
    .tw_d_i (tw_d_i),
    .vld_o  (s1_vld),
    .x1_re_o(s1_x1_re),
    .x1_im_o(s1_x1_im),
    .prod_o (s1_prod)
  );

  bfly_sum_stage #(
    .DATA_W(DATA_W)
  ) u_sum_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (s1_vld),
    .x1_re_i(s1_x1_re),
    .x1_im_i(s1_x1_im),
    .prod_i (s1_prod),
    .vld_o  (valid_o),
    .y1_re_o(y1_re_o),
    .y1_im_o(y1_im_o),
    .y2_re_o(y2_re_o),
    .y2_im_o(y2_im_o)
  );
endmodule

// File: rtl/radix2_bfly_chk.sv
module radix2_bfly_chk #(
  parameter int unsigned DATA_W = bfly_pkg::DEF_DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] x1_re_i,
  input logic [DATA_W-1:0] x1_im_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] y1_re_o,
  input logic [DATA_W-1:0] y1_im_o,
  input logic [DATA_W-1:0] y2_re_o,
  input logic [DATA_W-1:0] y2_im_o
);
  logic [DATA_W-1:0] re_sum, im_sum, re_dbl, im_dbl;

  // y1 + y2 cancels t and must equal 2*x1 modulo 2^DATA_W
  assign re_sum = y1_re_o + y2_re_o;
  assign im_sum = y1_im_o + y2_im_o;
  assign re_dbl = x1_re_i << 1;
  assign im_dbl = x1_im_i << 1;

  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (!valid_o && y1_re_o == '0 && y2_im_o == '0);
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);

  a_r2_valid_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 2));

  a_r5_sum_cancels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (re_sum == $past(re_dbl, 2)) && (im_sum == $past(im_dbl, 2)));

  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(y1_re_o) && $stable(y1_im_o) && $stable(y2_re_o) && $stable(y2_im_o));
endmodule

bind radix2_bfly radix2_bfly_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .x1_re_i(x1_re_i),
  .x1_im_i(x1_im_i),
  .valid_o(valid_o),
  .y1_re_o(y1_re_o),
  .y1_im_o(y1_im_o),
  .y2_re_o(y2_re_o),
  .y2_im_o(y2_im_o)
);

// File: tb/radix2_bfly_test.sv
`timescale 1ns/1ps
module radix2_bfly_test;
  localparam int W = 16;
  localparam int NV = 9;

  // x1re, x1im, x2re, x2im, c, d, y1re, y1im, y2re, y2im
  localparam int VEC [NV][10] = '{
    '{ 100,    -50,    200,  300, 16384,     0,    300,    250,  -100,   -350},
    '{   0,      0,   1000,-2000,     0, 16384,  -2000,  -1000,  2000,   1000},
    '{  10,     10,      3,    0,  8192,     0,     11,     10,     9,     10},
    '{   0,      0,     -3,    0,  8192,     0,     -2,      0,     2,      0},
    '{32767, -32768,     1,    1, 16384,     0, -32768, -32767, 32766,  32767},
    '{-1000,   500,    100,  200,  8192,  8192,   -850,    550, -1150,    450},
    '{   5,     -5,      1,    1,  8192,  8192,      5,     -5,     5,     -5},
    '{   0,      0,     -1,   -1,  8192,  8192,     -2,      0,     2,      0},
    '{   7,      7, -32768,    0, -32768,    0,      7,      7,     7,      7}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R4 unity twiddle";
      1: return "R4 minus-j twiddle";
      2: return "R3 positive floor";
      3: return "R3 negative floor";
      4: return "R6 wrap";
      5: return "R5 half twiddles";
      6: return "R9 per-term truncation";
      7: return "R9 negative terms";
      default: return "R3 slice bits 29:14";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [W-1:0] x1_re_i = '0, x1_im_i = '0, x2_re_i = '0, x2_im_i = '0;
  logic [W-1:0] tw_c_i = '0, tw_d_i = '0;
  logic valid_o;
  logic [W-1:0] y1_re_o, y1_im_o, y2_re_o, y2_im_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  radix2_bfly uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .x1_re_i(x1_re_i), .x1_im_i(x1_im_i), .x2_re_i(x2_re_i), .x2_im_i(x2_im_i),
    .tw_c_i(tw_c_i), .tw_d_i(tw_d_i), .valid_o(valid_o),
    .y1_re_o(y1_re_o), .y1_im_o(y1_im_o), .y2_re_o(y2_re_o), .y2_im_o(y2_im_o)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic drive(int i);
    valid_i = 1'b1;
    x1_re_i = W'(VEC[i][0]); x1_im_i = W'(VEC[i][1]);
    x2_re_i = W'(VEC[i][2]); x2_im_i = W'(VEC[i][3]);
    tw_c_i  = W'(VEC[i][4]); tw_d_i  = W'(VEC[i][5]);
  endtask

  task automatic idle();
    valid_i = 1'b0;
    x1_re_i = 16'h5a5a; x1_im_i = 16'h1234; x2_re_i = 16'h7fff; x2_im_i = 16'h7fff;
    tw_c_i = 16'h4000; tw_d_i = 16'h4000;
  endtask

  task automatic chk_result(int i, string req);
    chk({req, " valid_o"}, W'(valid_o), W'(1));
    chk({"R4 y1_re ", vtag(i)}, y1_re_o, W'(VEC[i][6]));
    chk({"R4 y1_im ", vtag(i)}, y1_im_o, W'(VEC[i][7]));
    chk({"R5 y2_re ", vtag(i)}, y2_re_o, W'(VEC[i][8]));
    chk({"R5 y2_im ", vtag(i)}, y2_im_o, W'(VEC[i][9]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid_o", W'(valid_o), W'(0));
    chk("R1 y1_re", y1_re_o, '0);
    chk("R1 y1_im", y1_im_o, '0);
    chk("R1 y2_re", y2_re_o, '0);
    chk("R1 y2_im", y2_im_o, '0);
    @(posedge clk); #1 rst_ni = 1'b1;

    // R8 back-to-back vector walk
    for (int i = 0; i < NV + 2; i++) begin
      @(posedge clk); #1;
      if (i < NV) drive(i); else idle();
      @(negedge clk);
      if (i >= 2) chk_result(i - 2, "R8");
    end

    // R7 hold while idle, R2 valid low
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 idle valid_o", W'(valid_o), W'(0));
      chk("R7 hold y1_re", y1_re_o, W'(VEC[NV-1][6]));
      chk("R7 hold y2_im", y2_im_o, W'(VEC[NV-1][9]));
    end

    // R2 single pulse latency
    @(posedge clk); #1 drive(5);
    @(negedge clk); chk("R2 cycle0 valid_o", W'(valid_o), W'(0));
    @(posedge clk); #1 idle();
    @(negedge clk); chk("R2 cycle1 valid_o", W'(valid_o), W'(0));
    @(negedge clk); chk_result(5, "R2 cycle2");
    @(negedge clk);
    chk("R2 cycle3 valid_o", W'(valid_o), W'(0));
    chk("R7 hold after pulse", y1_re_o, W'(VEC[5][6]));

    // R1 asynchronous reset mid-run
    #3 rst_ni = 1'b0;
    #1 chk("R1 async clear y1_re", y1_re_o, '0);
    chk("R1 async clear valid_o", W'(valid_o), W'(0));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule